// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load Interlock Unit

This block is the hazard logic of a five-stage in-order integer pipeline. Its stages are fetch, decode with register read, execute, memory and write-back. The block holds no state. It compares the source register numbers of the instructions in decode, execute and memory against the destination numbers, write enables and load flags carried by the three pipeline registers downstream of decode. From that comparison it produces operand-select codes for the two ALU inputs, a late store-data select for the memory stage, decode-time bypass selects, and a single stall line.

Registers are read in decode and written in write-back, so only read-after-write dependencies can occur. A newer producer is always chosen over an older one. Register 0 is hard-wired to zero and never causes a bypass or a stall. A load whose value is wanted by the very next instruction as an ALU operand causes exactly one bubble. If the next instruction is a store that only needs the loaded value as its data, there is no bubble: the value is bypassed from the write-back register into the memory stage. When stall is high, the surrounding pipeline holds the PC and the fetch/decode register and loads a no-op (write and memory enables cleared) into the decode/execute register.

Top module: `haz_unit`

## Requirements
- R1: When the EX/MEM stage writes a non-zero register that is not a load destination and that register equals an execute source, that operand's select is 2'b10.
- R2: When only the MEM/WB stage writes a non-zero register equal to an execute source, that operand's select is 2'b01. With no match the select is 2'b00 (register file).
- R3: When EX/MEM and MEM/WB both qualify for the same execute source, the select is 2'b10.
- R4: A source or destination numbered 0 never produces a non-zero select, a bypass or a stall. With all inputs at zero every output is zero.
- R5: stall is 1 when the ID/EX stage holds a load with write enable to a non-zero register that a used decode source names. Once the load has moved on to EX/MEM, stall is 0 for the same consumer, and the consumer's next cycle in execute picks 2'b01.
- R6: When the decode instruction is a store and the load destination matches only its data source (rs2), stall stays 0. A match on the store's address source (rs1) still stalls.
- R7: A decode source whose use flag is 0 never causes a stall.
- R8: A load destination held in EX/MEM is never selected (2'b10) for an execute operand. MEM/WB may still be selected for that operand.
- R9: fwd_st is 1 when the memory-stage instruction is a store whose rs2 equals a non-zero register that MEM/WB writes.
- R10: dec_byp_a / dec_byp_b are 1 when MEM/WB writes a non-zero register equal to decode rs1 / rs2, so a same-cycle write-back is visible to the decode read.
- R11: A destination whose write enable is 0 never produces a select, a bypass or a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs1 | input | AW | Decode source 1 (address source for stores) |
| dec_rs2 | input | AW | Decode source 2 (data source for stores) |
| dec_use_rs1 | input | 1 | Decode instruction reads source 1 |
| dec_use_rs2 | input | 1 | Decode instruction reads source 2 |
| dec_is_store | input | 1 | Decode instruction is a store |
| ex_rs1 | input | AW | Execute source 1 |
| ex_rs2 | input | AW | Execute source 2 |
| idx_rd | input | AW | ID/EX destination |
| idx_we | input | 1 | ID/EX write enable |
| idx_load | input | 1 | ID/EX holds a load |
| exm_rd | input | AW | EX/MEM destination |
| exm_we | input | 1 | EX/MEM write enable |
| exm_load | input | 1 | EX/MEM holds a load |
| exm_rs2 | input | AW | EX/MEM store data source |
| exm_store | input | 1 | EX/MEM holds a store |
| mwb_rd | input | AW | MEM/WB destination |
| mwb_we | input | 1 | MEM/WB write enable |
| fwd_a | output | 2 | ALU operand A select (00 RF, 01 MEM/WB, 10 EX/MEM) |
| fwd_b | output | 2 | ALU operand B select, same coding |
| fwd_st | output | 1 | Memory-stage store data taken from MEM/WB |
| dec_byp_a | output | 1 | Decode source 1 taken from MEM/WB write data |
| dec_byp_b | output | 1 | Decode source 2 taken from MEM/WB write data |
| stall | output | 1 | Hold PC and IF/ID, insert a bubble into ID/EX |

## Verification
The bench targets a dependency on register 0, which a careless comparator would forward or stall on, and a double match in EX/MEM and MEM/WB, where a wrong priority hands the ALU stale data. It runs the load-use sequence cycle by cycle to confirm one bubble and not two, and it checks that a load address sitting in EX/MEM is never forwarded as data. It probes the store cases from both sides: a store whose address depends on the load must stall, and one that only needs the load as data must not. A design that merged these two cases would either lose a cycle or send a wrong address to memory.

// File: rtl/haz_pkg.sv
package haz_pkg;
  // operand source encoding shared by both ALU inputs
  typedef enum logic [1:0] {
    OPS_RF = 2'b00,
    OPS_MW = 2'b01,
    OPS_EM = 2'b10
  } opsel_e;
endpackage

// File: rtl/haz_opnd_sel.sv
module haz_opnd_sel
  import haz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] exm_rd,
  input  logic          exm_we,
  input  logic          exm_load,
  input  logic [AW-1:0] mwb_rd,
  input  logic          mwb_we,
  output opsel_e        sel
);
  function automatic logic writes_reg(input logic [AW-1:0] s, input logic [AW-1:0] d,
                                      input logic we);
    return we && (d != '0) && (s == d);
  endfunction

  // named match events, visible to the checks below
  logic em_hit, mw_hit;
  assign em_hit = writes_reg(src, exm_rd, exm_we) && !exm_load;
  assign mw_hit = writes_reg(src, mwb_rd, mwb_we);

  always_comb begin
    if (em_hit)      sel = OPS_EM;
    else if (mw_hit) sel = OPS_MW;
    else             sel = OPS_RF;
  end

  always_comb begin
    assert_em_match_R1: assert (sel != OPS_EM || (exm_we && src == exm_rd))
      else $error("EX/MEM select without matching producer");
    assert_mw_match_R2: assert (sel != OPS_MW || (mwb_we && src == mwb_rd))
      else $error("MEM/WB select without matching producer");
    assert_em_first_R3: assert (!(exm_we && !exm_load && mwb_we && src == exm_rd && src == mwb_rd
                                  && src != '0) || sel == OPS_EM)
      else $error("older producer won over younger");
    assert_zero_reg_R4: assert (src != '0 || sel == OPS_RF)
      else $error("register 0 forwarded");
    assert_no_load_addr_R8: assert (!exm_load || sel != OPS_EM)
      else $error("load address forwarded as data");
  end
endmodule

// File: rtl/haz_interlock.sv
module haz_interlock #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] dec_rs1,
  input  logic [AW-1:0] dec_rs2,
  input  logic          dec_use_rs1,
  input  logic          dec_use_rs2,
  input  logic          dec_is_store,
  input  logic [AW-1:0] idx_rd,
  input  logic          idx_we,
  input  logic          idx_load,
  output logic          stall
);
  function automatic logic load_feeds(input logic [AW-1:0] s, input logic used);
    return used && idx_load && idx_we && (idx_rd != '0) && (s == idx_rd);
  endfunction

  logic hit_rs1, hit_rs2, rs2_late_ok;
  assign hit_rs1     = load_feeds(dec_rs1, dec_use_rs1);
  assign hit_rs2     = load_feeds(dec_rs2, dec_use_rs2);
  // store data is needed only in the memory stage, so a late bypass covers it
  assign rs2_late_ok = dec_is_store;
  assign stall       = hit_rs1 || (hit_rs2 && !rs2_late_ok);

  always_comb begin
    assert_stall_cause_R5: assert (!stall || (idx_load && idx_we))
      else $error("stall without a load in ID/EX");
    assert_stall_zero_R4: assert (!stall || idx_rd != '0)
      else $error("stall on register 0");
    assert_store_data_R6: assert (!(dec_is_store && !hit_rs1) || !stall)
      else $error("store data dependency stalled");
    assert_unused_src_R7: assert (!(!dec_use_rs1 && !dec_use_rs2) || !stall)
      else $error("stall with no used source");
  end
endmodule

// File: rtl/haz_wb_tap.sv
module haz_wb_tap #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          gate,
  input  logic [AW-1:0] mwb_rd,
  input  logic          mwb_we,
  output logic          take
);
  function automatic logic wb_match(input logic [AW-1:0] s, input logic [AW-1:0] d);
    return (d != '0) && (s == d);
  endfunction

  assign take = gate && mwb_we && wb_match(src, mwb_rd);

  always_comb begin
    assert_tap_we_R11: assert (!take || mwb_we)
      else $error("write-back tap without write enable");
    assert_tap_zero_R10: assert (!take || src != '0)
      else $error("write-back tap on register 0");
  end
endmodule

// File: rtl/haz_unit.sv
module haz_unit
  import haz_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic [AW-1:0] dec_rs1,
  input  logic [AW-1:0] dec_rs2,
  input  logic          dec_use_rs1,
  input  logic          dec_use_rs2,
  input  logic          dec_is_store,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] idx_rd,
  input  logic          idx_we,
  input  logic          idx_load,
  input  logic [AW-1:0] exm_rd,
  input  logic          exm_we,
  input  logic          exm_load,
  input  logic [AW-1:0] exm_rs2,
  input  logic          exm_store,
  input  logic [AW-1:0] mwb_rd,
  input  logic          mwb_we,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          fwd_st,
  output logic          dec_byp_a,
  output logic          dec_byp_b,
  output logic          stall
);
  localparam int N_OPND = 2;
  localparam int N_TAP  = 3;

  logic [AW-1:0] ex_src  [N_OPND];
  opsel_e        ex_sel  [N_OPND];
  logic [AW-1:0] tap_src [N_TAP];
  logic          tap_gate[N_TAP];
  logic          tap_take[N_TAP];

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  generate
    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
      haz_opnd_sel #(.AW(AW)) u_sel (
        .src(ex_src[i]), .exm_rd(exm_rd), .exm_we(exm_we), .exm_load(exm_load),
        .mwb_rd(mwb_rd), .mwb_we(mwb_we), .sel(ex_sel[i])
      );
    end
  endgenerate

  // taps on the write-back value: decode reads and memory-stage store data
  assign tap_src[0]  = dec_rs1;
  assign tap_src[1]  = dec_rs2;
  assign tap_src[2]  = exm_rs2;
  assign tap_gate[0] = 1'b1;
  assign tap_gate[1] = 1'b1;
  assign tap_gate[2] = exm_store;

  generate
    for (genvar j = 0; j < N_TAP; j++) begin : g_tap
      haz_wb_tap #(.AW(AW)) u_tap (
        .src(tap_src[j]), .gate(tap_gate[j]), .mwb_rd(mwb_rd), .mwb_we(mwb_we),
        .take(tap_take[j])
      );
    end
  endgenerate

  haz_interlock #(.AW(AW)) u_lock (
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_use_rs1(dec_use_rs1),
    .dec_use_rs2(dec_use_rs2), .dec_is_store(dec_is_store),
    .idx_rd(idx_rd), .idx_we(idx_we), .idx_load(idx_load), .stall(stall)
  );

  assign fwd_a     = ex_sel[0];
  assign fwd_b     = ex_sel[1];
  assign dec_byp_a = tap_take[0];
  assign dec_byp_b = tap_take[1];
  assign fwd_st    = tap_take[2];

  always_comb begin
    assert_sel_code_R2: assert ($onehot0(fwd_a) && $onehot0(fwd_b))
      else $error("illegal operand select code");
    assert_st_store_R9: assert (!fwd_st || (exm_store && exm_rs2 == mwb_rd))
      else $error("store data bypass without matching store");
  end
endmodule

// File: tb/sim_haz_unit.sv
module sim_haz_unit;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [AW-1:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, idx_rd, exm_rd, exm_rs2, mwb_rd;
  logic dec_use_rs1, dec_use_rs2, dec_is_store, idx_we, idx_load;
  logic exm_we, exm_load, exm_store, mwb_we;
  logic [1:0] fwd_a, fwd_b;
  logic fwd_st, dec_byp_a, dec_byp_b, stall;

  haz_unit u0 (
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_use_rs1(dec_use_rs1),
    .dec_use_rs2(dec_use_rs2), .dec_is_store(dec_is_store),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .idx_rd(idx_rd), .idx_we(idx_we),
    .idx_load(idx_load), .exm_rd(exm_rd), .exm_we(exm_we), .exm_load(exm_load),
    .exm_rs2(exm_rs2), .exm_store(exm_store), .mwb_rd(mwb_rd), .mwb_we(mwb_we),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_st(fwd_st), .dec_byp_a(dec_byp_a),
    .dec_byp_b(dec_byp_b), .stall(stall)
  );

  typedef struct {
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic idle();
    dec_rs1 = '0; dec_rs2 = '0; dec_use_rs1 = 0; dec_use_rs2 = 0; dec_is_store = 0;
    ex_rs1 = '0; ex_rs2 = '0; idx_rd = '0; idx_we = 0; idx_load = 0;
    exm_rd = '0; exm_we = 0; exm_load = 0; exm_rs2 = '0; exm_store = 0;
    mwb_rd = '0; mwb_we = 0;
  endtask

  task automatic start_vec();
    @(posedge clk);
    #1;
    idle();
  endtask

  // expected = {fwd_a, fwd_b, fwd_st, stall, dec_byp_a, dec_byp_b}
  task automatic expect_out(input logic [1:0] fa, input logic [1:0] fb, input logic st,
                            input logic stl, input logic ba, input logic bb, input string req);
    item_t it;
    it.exp = {fa, fb, st, stl, ba, bb};
    it.req = req;
    q.push_back(it);
  endtask

  // monitor: compare half a cycle after the driver changed the inputs
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it  = q.pop_front();
      got = {fwd_a, fwd_b, fwd_st, stall, dec_byp_a, dec_byp_b};
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s got=%b exp=%b", it.req, got, it.exp);
      end
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset / quiet state
    start_vec(); expect_out(2'b00, 2'b00, 0, 0, 0, 0, "R4 idle");
    // R1: EX/MEM ALU result to operand A
    start_vec(); exm_we = 1; exm_rd = 5; ex_rs1 = 5;
    expect_out(2'b10, 2'b00, 0, 0, 0, 0, "R1");
    // R2: MEM/WB to operand B
    start_vec(); mwb_we = 1; mwb_rd = 7; ex_rs2 = 7;
    expect_out(2'b00, 2'b01, 0, 0, 0, 0, "R2");
    // R3: both stages match, younger wins
    start_vec(); exm_we = 1; exm_rd = 9; mwb_we = 1; mwb_rd = 9; ex_rs1 = 9; ex_rs2 = 9;
    expect_out(2'b10, 2'b10, 0, 0, 0, 0, "R3");
    // R4: register 0 everywhere
    start_vec(); exm_we = 1; mwb_we = 1; idx_we = 1; idx_load = 1;
    dec_use_rs1 = 1; dec_use_rs2 = 1;
    expect_out(2'b00, 2'b00, 0, 0, 0, 0, "R4 zero");
    // R5: load-use sequence: stall, then released, then MEM/WB select
    start_vec(); idx_we = 1; idx_load = 1; idx_rd = 3; dec_rs1 = 3; dec_use_rs1 = 1;
    expect_out(2'b00, 2'b00, 0, 1, 0, 0, "R5 stall");
    start_vec(); exm_we = 1; exm_load = 1; exm_rd = 3; dec_rs1 = 3; dec_use_rs1 = 1;
    expect_out(2'b00, 2'b00, 0, 0, 0, 0, "R5 one bubble");
    start_vec(); mwb_we = 1; mwb_rd = 3; ex_rs1 = 3;
    expect_out(2'b01, 2'b00, 0, 0, 0, 0, "R5 follow-on");
    // R6: store needing load as data only / as address
    start_vec(); idx_we = 1; idx_load = 1; idx_rd = 4; dec_is_store = 1;
    dec_rs1 = 1; dec_rs2 = 4; dec_use_rs1 = 1; dec_use_rs2 = 1;
    expect_out(2'b00, 2'b00, 0, 0, 0, 0, "R6 data");
    start_vec(); idx_we = 1; idx_load = 1; idx_rd = 4; dec_is_store = 1;
    dec_rs1 = 4; dec_rs2 = 2; dec_use_rs1 = 1; dec_use_rs2 = 1;
    expect_out(2'b00, 2'b00, 0, 1, 0, 0, "R6 addr");
    // R5 with ALU rs2 (non-store) still stalls
    start_vec(); idx_we = 1; idx_load = 1; idx_rd = 8; dec_rs2 = 8; dec_use_rs2 = 1;
    expect_out(2'b00, 2'b00, 0, 1, 0, 0, "R5 rs2");
    // R7: unused source
    start_vec(); idx_we = 1; idx_load = 1; idx_rd = 6; dec_rs1 = 6; dec_rs2 = 6;
    expect_out(2'b00, 2'b00, 0, 0, 0, 0, "R7");
    // R8: load in EX/MEM not forwarded; MEM/WB still allowed
    start_vec(); exm_we = 1; exm_load = 1; exm_rd = 4; ex_rs2 = 4; mwb_we = 1; mwb_rd = 4;
    expect_out(2'b00, 2'b01, 0, 0, 0, 0, "R8 mw");
    start_vec(); exm_we = 1; exm_load = 1; exm_rd = 4; ex_rs1 = 4;
    expect_out(2'b00, 2'b00, 0, 0, 0, 0, "R8 none");
    // R9: store data in memory stage from MEM/WB
    start_vec(); exm_store = 1; exm_rs2 = 4; mwb_we = 1; mwb_rd = 4;
    expect_out(2'b00, 2'b00, 1, 0, 0, 0, "R9");
    start_vec(); exm_store = 0; exm_rs2 = 4; mwb_we = 1; mwb_rd = 4;
    expect_out(2'b00, 2'b00, 0, 0, 0, 0, "R9 no store");
    // R10: decode sees same-cycle write-back
    start_vec(); mwb_we = 1; mwb_rd = 12; dec_rs1 = 12; dec_rs2 = 12;
    expect_out(2'b00, 2'b00, 0, 0, 1, 1, "R10");
    start_vec(); mwb_we = 1; mwb_rd = 12; dec_rs1 = 12; dec_rs2 = 13;
    expect_out(2'b00, 2'b00, 0, 0, 1, 0, "R10 one side");
    // R11: write enables off
    start_vec(); exm_rd = 5; ex_rs1 = 5; mwb_rd = 5; ex_rs2 = 5; dec_rs1 = 5;
    exm_store = 1; exm_rs2 = 5; idx_rd = 5; idx_load = 1; dec_use_rs1 = 1;
    expect_out(2'b00, 2'b00, 0, 0, 0, 0, "R11");

    start_vec();
    wait (q.size() == 0);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule